// File: doc/BRIEF.md
# Three-Phase Sensor Readout Clock Sequencer

This block produces the digital clock levels that move charge through a frame-transfer image sensor built from three-phase cells. It drives three parallel (array) phases, three serial (output register) phases, the transfer gate next to the active serial register, the summing well and the reset gate. It also drives a one-cycle sample strobe that tells an off-chip converter when to take the reference level and when to take the signal level of each output pixel, so the converter can do correlated double sampling. All timing comes from one system clock. Each step of a phase sequence lasts a fixed number of ticks, and the parallel and serial paths can use different tick counts.

A readout starts when a start request arrives while the block is idle. For every binned row, the block first shifts the array down by up to V rows with the serial clocks held fixed. It then reads the serial register out pixel by pixel: a reset-gate pulse, a reference strobe, one or more serial shifts into the summing well, the falling edge of the summing well, and a signal strobe. The overscan pixels come first and each is read on its own. The imaging pixels are grouped H at a time. While the integrate input is high in idle, the block flushes the serial register with continuous serial clocking and leaves the array untouched.

Top module: `ccd_clk_seq`

## Requirements
- R1: After reset, and while idle, both phase buses sit at rest with only phase 1 high (value 3'b001: bit 0 is phase 1, bit 1 is phase 2, bit 2 is phase 3). The transfer gate, summing well, reset gate, strobe, busy and done are all low.
- R2: One shift of either phase bus walks the values 3'b011, 3'b010, 3'b110, 3'b100, 3'b101 and then returns to 3'b001. The rest value 3'b001 also counts as a step. Every step lasts PAR_STEP_TICKS cycles on the parallel bus and SER_STEP_TICKS cycles on the serial bus.
- R3: The two phase buses are never away from rest at the same time. Whichever bus is not shifting holds 3'b001.
- R4: A frame makes exactly ROWS parallel shifts, grouped into ceil(ROWS/V) groups of at most V shifts, where V is the vertical bin input latched at start and a value of 0 counts as 1. The transfer gate is high for the whole of each group and falls once per group.
- R5: After each group the serial register gets OVERSCAN+COLS shifts. These form OVERSCAN single-shift overscan pixels followed by ceil(COLS/H) imaging groups of at most H shifts, where H is the horizontal bin input latched at start and a value of 0 counts as 1. The summing well is high during each pixel's shifts and falls exactly once per output pixel.
- R6: Before every fall of the summing well, the reset gate has pulsed high since the previous fall, and it is low when the summing well falls.
- R7: Every output pixel gives two one-cycle strobes. The first comes after the reset gate settles and before the summing well rises; the second comes after the summing well falls and its settle time has passed. A strobe never occurs while the summing well is high.
- R8: After the last row, done is high for exactly one cycle, and the block then returns to idle.
- R9: A start request that arrives while a frame is being read out is ignored. No second frame follows.
- R10: When integrate is high in idle, the block flushes: the serial bus shifts continuously, the reset gate and summing well are high, the parallel bus stays at rest, and there is no strobe and no transfer gate. After integrate falls, the current serial shift completes and the block goes idle. If integrate rises during a readout, it takes effect only after done.
- R11: The transfer gate next to the unused serial register is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame readout request, acted on only when idle |
| integrate_i | input | 1 | High selects integration (flush clocking) when idle |
| vbin_i | input | BIN_W | Vertical binning factor (0 counts as 1) |
| hbin_i | input | BIN_W | Horizontal binning factor (0 counts as 1) |
| par_ph_o | output | 3 | Parallel phase levels, bit 0 = phase 1 |
| ser_ph_o | output | 3 | Serial phase levels, bit 0 = phase 1 |
| tg_o | output | 1 | Transfer gate beside the active serial register |
| tg_upper_o | output | 1 | Transfer gate beside the unused serial register, held low |
| sw_o | output | 1 | Summing well |
| rg_o | output | 1 | Reset gate |
| strobe_o | output | 1 | Converter sample strobe |
| busy_o | output | 1 | High whenever the block is not idle |
| done_o | output | 1 | One-cycle pulse after the last row |

## Verification
The hardest case to reach is a final parallel group or final serial group that is shorter than the bin factor, because the remainder logic only runs when a bin factor does not divide the array size. To reach it, the bench uses a small array with prime dimensions (5 rows, 7 columns) and sweeps every vertical and horizontal bin value, including 0 and values larger than the array. Every combination therefore produces a remainder group, a full-size bin, or a bin that swallows the whole array. The bench raises integrate and start in the middle of a frame to show that the readout completes unchanged and that flushing begins only after done.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   localparam int unsigned PHASE_STEPS = 6;

   typedef enum logic [3:0] {
      S_IDLE,
      S_FLUSH,
      S_PSHIFT,
      S_RG_HI,
      S_RG_SET,
      S_SMP_REF,
      S_SSHIFT,
      S_SW_SET,
      S_SMP_SIG,
      S_DONE
   } seq_state_t;

   // Step 0 is the rest level; each step overlaps its neighbours by one phase.
   function automatic logic [2:0] phase_of_step(input logic [2:0] step);
      case (step)
         3'd0:    phase_of_step = 3'b001;
         3'd1:    phase_of_step = 3'b011;
         3'd2:    phase_of_step = 3'b010;
         3'd3:    phase_of_step = 3'b110;
         3'd4:    phase_of_step = 3'b100;
         3'd5:    phase_of_step = 3'b101;
         default: phase_of_step = 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/ccd_phase_stepper.sv
module ccd_phase_stepper
   import ccd_seq_pkg::*;
#(
   parameter int unsigned STEP_TICKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   output logic [2:0] phase_o,
   output logic       last_o
);

   localparam int unsigned TW       = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
   localparam logic [TW-1:0] TICK_END = TW'(STEP_TICKS - 1);
   localparam logic [2:0]    STEP_END = 3'(PHASE_STEPS - 1);

   if (STEP_TICKS < 1) begin : g_bad_ticks
      $error("ccd_phase_stepper: STEP_TICKS must be at least 1");
   end

   logic [2:0]    step_q;
   logic [TW-1:0] tick_q;
   logic          tick_end;

   assign tick_end = (tick_q == TICK_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         tick_q <= '0;
      end else if (!run_i) begin
         step_q <= '0;
         tick_q <= '0;
      end else if (tick_end) begin
         tick_q <= '0;
         step_q <= (step_q == STEP_END) ? 3'd0 : step_q + 3'd1;
      end else begin
         tick_q <= tick_q + TW'(1);
      end
   end

   assign last_o  = run_i && tick_end && (step_q == STEP_END);
   assign phase_o = phase_of_step(step_q);

endmodule

// File: rtl/ccd_readout_fsm.sv
module ccd_readout_fsm
   import ccd_seq_pkg::*;
#(
   parameter int unsigned ROWS         = 512,
   parameter int unsigned COLS         = 512,
   parameter int unsigned OVERSCAN     = 15,
   parameter int unsigned RG_TICKS     = 2,
   parameter int unsigned SETTLE_TICKS = 4,
   parameter int unsigned BIN_W        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             integrate_i,
   input  logic [BIN_W-1:0] vbin_i,
   input  logic [BIN_W-1:0] hbin_i,
   input  logic             par_last_i,
   input  logic             ser_last_i,
   output logic             par_run_o,
   output logic             ser_run_o,
   output logic             tg_o,
   output logic             sw_o,
   output logic             rg_o,
   output logic             strobe_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int unsigned RW    = $clog2(ROWS + 1);
   localparam int unsigned CW    = $clog2(COLS + 1);
   localparam int unsigned OW    = (OVERSCAN > 0) ? $clog2(OVERSCAN + 1) : 1;
   localparam int unsigned TMAX  = (RG_TICKS > SETTLE_TICKS) ? RG_TICKS : SETTLE_TICKS;
   localparam int unsigned TMW   = (TMAX > 1) ? $clog2(TMAX) : 1;
   localparam int unsigned CMP_W = (BIN_W > CW) ? BIN_W : CW;
   localparam logic [TMW-1:0] RG_LOAD  = TMW'(RG_TICKS - 1);
   localparam logic [TMW-1:0] SET_LOAD = TMW'(SETTLE_TICKS - 1);

   if (ROWS < 1 || COLS < 1 || RG_TICKS < 1 || SETTLE_TICKS < 1 || BIN_W < 1)
   begin : g_bad_cfg
      $error("ccd_readout_fsm: array size, tick counts and BIN_W must be at least 1");
   end

   seq_state_t       state_q;
   logic [RW-1:0]    rows_left_q;
   logic [CW-1:0]    cols_left_q;
   logic [OW-1:0]    ovs_left_q;
   logic [BIN_W-1:0] vbin_q;
   logic [BIN_W-1:0] hbin_q;
   logic [BIN_W-1:0] grp_cnt_q;
   logic [BIN_W-1:0] sh_left_q;
   logic [TMW-1:0]   tmr_q;

   // Width of the next imaging group: the smaller of the bin and the columns left.
   logic [CMP_W-1:0] hb_x, cl_x;
   logic [BIN_W-1:0] img_grp;
   logic             group_end, row_end;

   assign hb_x      = CMP_W'(hbin_q);
   assign cl_x      = CMP_W'(cols_left_q);
   assign img_grp   = BIN_W'((hb_x < cl_x) ? hb_x : cl_x);
   assign group_end = (grp_cnt_q + BIN_W'(1) == vbin_q) || (rows_left_q == RW'(1));
   assign row_end   = (ovs_left_q == '0) && (cols_left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         rows_left_q <= '0;
         cols_left_q <= '0;
         ovs_left_q  <= '0;
         vbin_q      <= BIN_W'(1);
         hbin_q      <= BIN_W'(1);
         grp_cnt_q   <= '0;
         sh_left_q   <= '0;
         tmr_q       <= '0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (integrate_i) begin
                  state_q <= S_FLUSH;
               end else if (start_i) begin
                  vbin_q      <= (vbin_i == '0) ? BIN_W'(1) : vbin_i;
                  hbin_q      <= (hbin_i == '0) ? BIN_W'(1) : hbin_i;
                  rows_left_q <= RW'(ROWS);
                  grp_cnt_q   <= '0;
                  state_q     <= S_PSHIFT;
               end
            end
            S_FLUSH: begin
               if (ser_last_i && !integrate_i) state_q <= S_IDLE;
            end
            S_PSHIFT: begin
               if (par_last_i) begin
                  rows_left_q <= rows_left_q - RW'(1);
                  if (group_end) begin
                     grp_cnt_q   <= '0;
                     ovs_left_q  <= OW'(OVERSCAN);
                     cols_left_q <= CW'(COLS);
                     tmr_q       <= RG_LOAD;
                     state_q     <= S_RG_HI;
                  end else begin
                     grp_cnt_q <= grp_cnt_q + BIN_W'(1);
                  end
               end
            end
            S_RG_HI: begin
               if (tmr_q == '0) begin
                  tmr_q   <= SET_LOAD;
                  state_q <= S_RG_SET;
               end else begin
                  tmr_q <= tmr_q - TMW'(1);
               end
            end
            S_RG_SET: begin
               if (tmr_q == '0) state_q <= S_SMP_REF;
               else             tmr_q   <= tmr_q - TMW'(1);
            end
            S_SMP_REF: begin
               sh_left_q <= (ovs_left_q != '0) ? BIN_W'(1) : img_grp;
               state_q   <= S_SSHIFT;
            end
            S_SSHIFT: begin
               if (ser_last_i) begin
                  if (ovs_left_q != '0) ovs_left_q  <= ovs_left_q - OW'(1);
                  else                  cols_left_q <= cols_left_q - CW'(1);
                  if (sh_left_q == BIN_W'(1)) begin
                     tmr_q   <= SET_LOAD;
                     state_q <= S_SW_SET;
                  end else begin
                     sh_left_q <= sh_left_q - BIN_W'(1);
                  end
               end
            end
            S_SW_SET: begin
               if (tmr_q == '0) state_q <= S_SMP_SIG;
               else             tmr_q   <= tmr_q - TMW'(1);
            end
            S_SMP_SIG: begin
               if (row_end) begin
                  state_q <= (rows_left_q == '0) ? S_DONE : S_PSHIFT;
               end else begin
                  tmr_q   <= RG_LOAD;
                  state_q <= S_RG_HI;
               end
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign par_run_o = (state_q == S_PSHIFT);
   assign ser_run_o = (state_q == S_SSHIFT) || (state_q == S_FLUSH);
   assign tg_o      = (state_q == S_PSHIFT);
   assign sw_o      = (state_q == S_SSHIFT) || (state_q == S_FLUSH);
   assign rg_o      = (state_q == S_RG_HI)  || (state_q == S_FLUSH);
   assign strobe_o  = (state_q == S_SMP_REF) || (state_q == S_SMP_SIG);
   assign busy_o    = (state_q != S_IDLE);
   assign done_o    = (state_q == S_DONE);

endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq #(
   parameter int unsigned ROWS           = 512,
   parameter int unsigned COLS           = 512,
   parameter int unsigned OVERSCAN       = 15,
   parameter int unsigned PAR_STEP_TICKS = 8,
   parameter int unsigned SER_STEP_TICKS = 2,
   parameter int unsigned RG_TICKS       = 2,
   parameter int unsigned SETTLE_TICKS   = 4,
   parameter int unsigned BIN_W          = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             integrate_i,
   input  logic [BIN_W-1:0] vbin_i,
   input  logic [BIN_W-1:0] hbin_i,
   output logic [2:0]       par_ph_o,
   output logic [2:0]       ser_ph_o,
   output logic             tg_o,
   output logic             tg_upper_o,
   output logic             sw_o,
   output logic             rg_o,
   output logic             strobe_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int unsigned N_CHAN = 2;   // channel 0 parallel, channel 1 serial

   logic [N_CHAN-1:0] run_w;
   logic [N_CHAN-1:0] last_w;
   logic [2:0]        phase_w [N_CHAN];
   logic              par_run, ser_run;

   ccd_readout_fsm #(
      .ROWS         (ROWS),
      .COLS         (COLS),
      .OVERSCAN     (OVERSCAN),
      .RG_TICKS     (RG_TICKS),
      .SETTLE_TICKS (SETTLE_TICKS),
      .BIN_W        (BIN_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .integrate_i (integrate_i),
      .vbin_i      (vbin_i),
      .hbin_i      (hbin_i),
      .par_last_i  (last_w[0]),
      .ser_last_i  (last_w[1]),
      .par_run_o   (par_run),
      .ser_run_o   (ser_run),
      .tg_o        (tg_o),
      .sw_o        (sw_o),
      .rg_o        (rg_o),
      .strobe_o    (strobe_o),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   assign run_w = {ser_run, par_run};

   for (genvar gi = 0; gi < N_CHAN; gi++) begin : g_chan
      localparam int unsigned TICKS = (gi == 0) ? PAR_STEP_TICKS : SER_STEP_TICKS;
      ccd_phase_stepper #(.STEP_TICKS(TICKS)) u_step (
         .clk     (clk),
         .rst_n   (rst_n),
         .run_i   (run_w[gi]),
         .phase_o (phase_w[gi]),
         .last_o  (last_w[gi])
      );
   end

   assign par_ph_o   = phase_w[0];
   assign ser_ph_o   = phase_w[1];
   assign tg_upper_o = 1'b0;

endmodule

// File: rtl/ccd_clk_seq_chk.sv
module ccd_clk_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] par_ph,
   input logic [2:0] ser_ph,
   input logic       tg,
   input logic       sw,
   input logic       rg,
   input logic       strobe,
   input logic       busy,
   input logic       done
);

   function automatic logic [2:0] after(input logic [2:0] v);
      case (v)
         3'b001:  after = 3'b011;
         3'b011:  after = 3'b010;
         3'b010:  after = 3'b110;
         3'b110:  after = 3'b100;
         3'b100:  after = 3'b101;
         3'b101:  after = 3'b001;
         default: after = 3'b000;
      endcase
   endfunction

   a_r2_par_order: assert property (@(posedge clk) disable iff (!rst_n)
      (par_ph != $past(par_ph)) |-> (par_ph == after($past(par_ph))));

   a_r2_ser_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_ph != $past(ser_ph)) |-> (ser_ph == after($past(ser_ph))));

   a_r3_one_bus_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (par_ph != 3'b001) |-> (ser_ph == 3'b001));

   a_r4_tg_covers_par: assert property (@(posedge clk) disable iff (!rst_n)
      (par_ph != 3'b001) |-> tg);

   a_r6_rg_low_at_sw_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw) |-> !rg);

   a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   a_r7_strobe_sw_low: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !sw);

   a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rg && ser_ph != 3'b001) |-> (par_ph == 3'b001 && !strobe && !tg));

endmodule

bind ccd_clk_seq ccd_clk_seq_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .par_ph (par_ph_o),
   .ser_ph (ser_ph_o),
   .tg     (tg_o),
   .sw     (sw_o),
   .rg     (rg_o),
   .strobe (strobe_o),
   .busy   (busy_o),
   .done   (done_o)
);

// File: tb/test_ccd_clk_seq.sv
`timescale 1ns/1ps
module test_ccd_clk_seq;

   localparam int ROWS = 5;
   localparam int COLS = 7;
   localparam int OVS  = 2;
   localparam int PT   = 3;
   localparam int ST   = 2;
   localparam int RGT  = 1;
   localparam int SET  = 2;
   localparam int BW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic integ = 1'b0;
   logic [BW-1:0] vbin = '0;
   logic [BW-1:0] hbin = '0;
   logic [2:0] par_ph, ser_ph;
   logic tg, tg_up, sw, rg, strobe, busy, done;

   always #2.5 clk = ~clk;

   ccd_clk_seq #(
      .ROWS(ROWS), .COLS(COLS), .OVERSCAN(OVS), .PAR_STEP_TICKS(PT),
      .SER_STEP_TICKS(ST), .RG_TICKS(RGT), .SETTLE_TICKS(SET), .BIN_W(BW)
   ) i_ccd_clk_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .integrate_i(integ),
      .vbin_i(vbin), .hbin_i(hbin), .par_ph_o(par_ph), .ser_ph_o(ser_ph),
      .tg_o(tg), .tg_upper_o(tg_up), .sw_o(sw), .rg_o(rg), .strobe_o(strobe),
      .busy_o(busy), .done_o(done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R8 watchdog: actual no completion expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // observation state
   logic [2:0] p_par = 3'b001, p_ser = 3'b001;
   bit p_tg = 0, p_sw = 0, p_rg = 0, rg_seen = 0;
   int par_run = 0, ser_run = 0;
   int par_sh, ser_sh, par_chg, tg_fall, tg_hi, sw_fall, strb, dones;
   int v2, v3, v6, v7, v11, rg_lo, busy_hi;

   function automatic logic [2:0] nxt(input logic [2:0] v);
      case (v)
         3'b001: nxt = 3'b011; 3'b011: nxt = 3'b010; 3'b010: nxt = 3'b110;
         3'b110: nxt = 3'b100; 3'b100: nxt = 3'b101; 3'b101: nxt = 3'b001;
         default: nxt = 3'b000;
      endcase
   endfunction

   task automatic clear_counts();
      par_sh = 0; ser_sh = 0; par_chg = 0; tg_fall = 0; tg_hi = 0; sw_fall = 0;
      strb = 0; dones = 0; v2 = 0; v3 = 0; v6 = 0; v7 = 0; v11 = 0; rg_lo = 0;
      busy_hi = 0;
   endtask

   task automatic sample();
      @(negedge clk);
      if (par_ph != p_par) begin
         par_chg++;
         if (p_par == 3'b101 && par_ph == 3'b001) par_sh++;
         if (nxt(p_par) != par_ph) v2++;
         if (p_par != 3'b001 && par_run != PT) v2++;
         par_run = 1;
      end else par_run++;
      if (ser_ph != p_ser) begin
         if (p_ser == 3'b101 && ser_ph == 3'b001) ser_sh++;
         if (nxt(p_ser) != ser_ph) v2++;
         if (p_ser != 3'b001 && ser_run != ST) v2++;
         ser_run = 1;
      end else ser_run++;
      if (par_ph != 3'b001 && ser_ph != 3'b001) v3++;
      if (p_tg && !tg) tg_fall++;
      if (tg) tg_hi++;
      if (rg && !p_rg) rg_seen = 1;
      if (p_sw && !sw) begin
         sw_fall++;
         if (rg || !rg_seen) v6++;
         rg_seen = 0;
      end
      if (strobe) begin strb++; if (sw) v7++; end
      if (done) dones++;
      if (tg_up) v11++;
      if (!rg) rg_lo++;
      if (busy) busy_hi++;
      p_par = par_ph; p_ser = ser_ph; p_tg = tg; p_sw = sw; p_rg = rg;
   endtask

   task automatic run_frame(input int v, input int h, input bit inj_start, input bit inj_int);
      int vv, hh, grp, pix, n;
      vv = (v == 0) ? 1 : v;
      hh = (h == 0) ? 1 : h;
      grp = (ROWS + vv - 1) / vv;
      pix = OVS + (COLS + hh - 1) / hh;
      clear_counts();
      vbin = BW'(v); hbin = BW'(h); start = 1'b1;
      sample();
      start = 1'b0;
      n = 0;
      while (dones == 0) begin
         sample();
         n++;
         if (n == 60) begin
            if (inj_start) start = 1'b1;
            if (inj_int) integ = 1'b1;
         end
         if (n == 61) start = 1'b0;
      end
      check(par_sh == ROWS, "R4 parallel shifts", par_sh, ROWS);
      check(tg_fall == grp, "R4 transfer gate groups", tg_fall, grp);
      check(ser_sh == grp * (OVS + COLS), "R5 serial shifts", ser_sh, grp * (OVS + COLS));
      check(sw_fall == grp * pix, "R5 summing well falls", sw_fall, grp * pix);
      check(strb == 2 * grp * pix, "R7 strobes", strb, 2 * grp * pix);
      check(v2 == 0, "R2 step order and length", v2, 0);
      check(v3 == 0, "R3 both buses moving", v3, 0);
      check(v6 == 0, "R6 reset gate before summing fall", v6, 0);
      check(v7 == 0, "R7 strobe with summing well high", v7, 0);
      check(v11 == 0, "R11 upper transfer gate", v11, 0);
      check(dones == 1, "R8 done pulses", dones, 1);
      sample();
      check(busy == 1'b0, "R8 idle after done", int'(busy), 0);
   endtask

   initial begin
      // R1: reset and idle state
      repeat (3) sample();
      check(par_ph == 3'b001 && ser_ph == 3'b001, "R1 phases at rest in reset",
            int'({par_ph, ser_ph}), 6'o11);
      rst_n = 1'b1;
      repeat (4) sample();
      check({tg, sw, rg, strobe, busy, done} == 6'b0, "R1 controls low when idle",
            int'({tg, sw, rg, strobe, busy, done}), 0);
      check(par_ph == 3'b001 && ser_ph == 3'b001, "R1 phases at rest when idle",
            int'({par_ph, ser_ph}), 6'o11);

      // R4 R5: sweep all bin codes, including 0 and bins above the array size
      for (int v = 0; v < (1 << BW); v++)
         for (int h = 0; h < (1 << BW); h++)
            run_frame(v, h, 1'b0, 1'b0);

      // R9: start during readout is ignored
      run_frame(2, 3, 1'b1, 1'b0);
      clear_counts();
      repeat (30) sample();
      check(busy_hi == 0, "R9 no second frame after ignored start", busy_hi, 0);

      // R10: flush from idle
      integ = 1'b1;
      sample(); sample();
      clear_counts();
      repeat (80) sample();
      check(ser_sh >= 5, "R10 serial flushing", ser_sh, 5);
      check(par_chg == 0, "R10 parallel bus static", par_chg, 0);
      check(strb == 0, "R10 no strobe in flush", strb, 0);
      check(tg_hi == 0, "R10 no transfer gate in flush", tg_hi, 0);
      check(rg_lo == 0, "R10 reset gate high in flush", rg_lo, 0);
      integ = 1'b0;
      for (int i = 0; i < 6 * ST + 4 && busy; i++) sample();
      check(busy == 1'b0, "R10 idle after integrate drops", int'(busy), 0);
      check(ser_ph == 3'b001, "R10 serial at rest after flush", int'(ser_ph), 1);

      // R10: integrate raised mid-frame waits for frame end
      run_frame(3, 2, 1'b0, 1'b1);
      sample();
      check(busy == 1'b1 && rg == 1'b1, "R10 flush entered at frame end",
            int'({busy, rg}), 3);
      integ = 1'b0;
      for (int i = 0; i < 6 * ST + 4 && busy; i++) sample();
      check(busy == 1'b0, "R10 idle after late flush", int'(busy), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule